// File: doc/BRIEF.md
# Keyboard and Display Register Interface

This block sits on the load/store bus of a 16-bit processor and exposes four word registers: a keyboard status word, a keyboard data word, a display status word and a display data word. A program polls a status word with a sign test. Bit 15 set means the device is ready. It then reads the typed character, or writes the next character to show.

The ready flags cannot be written by software. Device events set them. Bus accesses clear them as a side effect:
- A keyboard strobe loads an 8-bit ASCII code and raises keyboard ready. The first enabled read of the keyboard data word drops it.
- An enabled write to the display data word hands the character to the display sink and drops display ready. The sink's completion pulse raises display ready again.

Top module: `kbd_disp_mmio`

## Requirements
- R1: After reset, keyboard ready is 0, display ready is 1, the display valid output is 0, and both stored characters are 0.
- R2: With mem_en_i high and mem_we_i low, rdata_o returns one of four words. Address 0xFE00 gives the keyboard status word and 0xFE02 the keyboard data word. Address 0xFE04 gives the display status word and 0xFE06 the display data word. A status word has its ready flag in bit 15 and zeros in bits 14:0. A data word is its character zero-extended from bits 7:0. Any other address, and any cycle without an enabled read, returns 0.
- R3: A cycle with key_strobe_i high loads key_code_i into the keyboard data word and sets keyboard ready. If ready was already 1, the code is overwritten and ready stays 1.
- R4: An enabled read of 0xFE02 clears keyboard ready at the next edge. A cycle with mem_en_i low, or with a write, leaves it unchanged.
- R5: When a key strobe and an enabled read of 0xFE02 occur in the same cycle, the strobe wins: ready stays 1 and the new code is stored.
- R6: An enabled write to 0xFE06 while display ready is 1 stores wdata_i[7:0], clears display ready, and drives disp_valid_o high with that character on disp_char_o.
- R7: disp_valid_o stays high until a disp_done_i pulse. That pulse drops disp_valid_o and sets display ready. disp_done_i is ignored while disp_valid_o is low.
- R8: An enabled write to 0xFE06 while display ready is 0 is dropped, so the stored character is unchanged.
- R9: Writes to 0xFE00 and 0xFE04 change no state. A read of 0xFE06 returns the last accepted character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mem_en_i | input | 1 | Bus access strobe |
| mem_we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 16 | Bus address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data (combinational) |
| key_strobe_i | input | 1 | Key typed this cycle |
| key_code_i | input | 8 | ASCII code of typed key |
| disp_char_o | output | 8 | Character offered to the display sink |
| disp_valid_o | output | 1 | Character pending at the sink |
| disp_done_i | input | 1 | Sink finished showing the character |

## Verification
Assertions check the flag transitions on every cycle:
- a strobe sets keyboard ready, and a lone keyboard data read clears it;
- otherwise keyboard ready holds;
- an accepted display write drops display ready and raises valid;
- valid persists until the completion pulse;
- a dropped write leaves the character alone;
- status reads have bits 14:0 clear.

Only the bench scenarios show the rest:
- that the correct character reaches the bus on each read;
- that writes to status addresses and unmapped addresses leave the data untouched;
- that a random mix of polling, typing and display traffic keeps both devices consistent with a reference model.

// File: rtl/kd_pkg.sv
package kd_pkg;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned CHAR_W = 8;
  localparam int unsigned NREG   = 4;
  localparam logic [ADDR_W-1:0] REG_BASE = 16'hFE00;
  localparam int unsigned REG_STRIDE = 2;
  // register slots; order fixes the address map
  localparam int unsigned SLOT_KSTAT = 0;
  localparam int unsigned SLOT_KDATA = 1;
  localparam int unsigned SLOT_DSTAT = 2;
  localparam int unsigned SLOT_DDATA = 3;
endpackage

// File: rtl/kd_decode.sv
module kd_decode #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned NREG = 4,
  parameter logic [ADDR_W-1:0] BASE = '0,
  parameter int unsigned STRIDE = 2
) (
  input  logic              en_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [NREG-1:0]   rd_sel_o,
  output logic [NREG-1:0]   wr_sel_o
);
  logic [NREG-1:0] hit;

  for (genvar i = 0; i < NREG; i++) begin : g_slot
    localparam logic [ADDR_W-1:0] SlotAddr = BASE + ADDR_W'(i * STRIDE);
    assign hit[i]      = (addr_i == SlotAddr);
    assign rd_sel_o[i] = en_i & ~we_i & hit[i];
    assign wr_sel_o[i] = en_i &  we_i & hit[i];
  end
endmodule

// File: rtl/kd_kbd_port.sv
module kd_kbd_port #(
  parameter int unsigned CHAR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              strobe_i,
  input  logic [CHAR_W-1:0] code_i,
  input  logic              rd_i,
  output logic              ready_o,
  output logic [CHAR_W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ready_o <= 1'b0;
      data_o  <= '0;
    end else if (strobe_i) begin
      ready_o <= 1'b1;  // set beats clear
      data_o  <= code_i;
    end else if (rd_i) begin
      ready_o <= 1'b0;
    end
  end

  AST_KBD_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i |=> ready_o && data_o == $past(code_i));  // R3
  AST_KBD_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && !strobe_i |=> !ready_o);  // R4
  AST_KBD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i && !strobe_i |=> $stable(ready_o) && $stable(data_o));  // R4
endmodule

// File: rtl/kd_disp_port.sv
module kd_disp_port #(
  parameter int unsigned CHAR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [CHAR_W-1:0] wdata_i,
  input  logic              done_i,
  output logic              ready_o,
  output logic [CHAR_W-1:0] char_o,
  output logic              valid_o
);
  logic accept;
  assign accept = wr_i & ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ready_o <= 1'b1;
      valid_o <= 1'b0;
      char_o  <= '0;
    end else if (accept) begin
      ready_o <= 1'b0;
      valid_o <= 1'b1;
      char_o  <= wdata_i;
    end else if (valid_o && done_i) begin
      ready_o <= 1'b1;
      valid_o <= 1'b0;
    end
  end

  AST_DISP_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && ready_o |=> !ready_o && valid_o && char_o == $past(wdata_i));  // R6
  AST_DISP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !done_i |=> valid_o && $stable(char_o));  // R7
  AST_DISP_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && done_i |=> ready_o && !valid_o);  // R7
  AST_DISP_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && !ready_o |=> $stable(char_o));  // R8
endmodule

// File: rtl/kbd_disp_mmio.sv
module kbd_disp_mmio
  import kd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mem_en_i,
  input  logic              mem_we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              key_strobe_i,
  input  logic [CHAR_W-1:0] key_code_i,
  output logic [CHAR_W-1:0] disp_char_o,
  output logic              disp_valid_o,
  input  logic              disp_done_i
);
  localparam int unsigned PadW = DATA_W - CHAR_W;

  logic [NREG-1:0]   rd_sel, wr_sel;
  logic              kbd_ready, disp_ready;
  logic [CHAR_W-1:0] kbd_data;

  kd_decode #(
    .ADDR_W(ADDR_W), .NREG(NREG), .BASE(REG_BASE), .STRIDE(REG_STRIDE)
  ) u_decode (
    .en_i    (mem_en_i),
    .we_i    (mem_we_i),
    .addr_i  (addr_i),
    .rd_sel_o(rd_sel),
    .wr_sel_o(wr_sel)
  );

  kd_kbd_port #(.CHAR_W(CHAR_W)) u_kbd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .strobe_i(key_strobe_i),
    .code_i  (key_code_i),
    .rd_i    (rd_sel[SLOT_KDATA]),
    .ready_o (kbd_ready),
    .data_o  (kbd_data)
  );

  kd_disp_port #(.CHAR_W(CHAR_W)) u_disp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (wr_sel[SLOT_DDATA]),
    .wdata_i(wdata_i[CHAR_W-1:0]),
    .done_i (disp_done_i),
    .ready_o(disp_ready),
    .char_o (disp_char_o),
    .valid_o(disp_valid_o)
  );

  // status writes (wr_sel slots 0 and 2) intentionally unconnected in effect
  always_comb begin
    rdata_o = '0;
    if (rd_sel[SLOT_KSTAT]) rdata_o[DATA_W-1] = kbd_ready;
    if (rd_sel[SLOT_KDATA]) rdata_o = {{PadW{1'b0}}, kbd_data};
    if (rd_sel[SLOT_DSTAT]) rdata_o[DATA_W-1] = disp_ready;
    if (rd_sel[SLOT_DDATA]) rdata_o = {{PadW{1'b0}}, disp_char_o};
  end

  AST_SEL_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(rd_sel | wr_sel));  // R2
  AST_STAT_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_sel[SLOT_KSTAT] || rd_sel[SLOT_DSTAT] |-> rdata_o[DATA_W-2:0] == '0);  // R2
  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_en_i |-> rdata_o == '0);  // R2
endmodule

// File: tb/kbd_disp_mmio_bench.sv
module kbd_disp_mmio_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        mem_en_i = 1'b0, mem_we_i = 1'b0;
  logic [15:0] addr_i = '0, wdata_i = '0;
  logic [15:0] rdata_o;
  logic        key_strobe_i = 1'b0;
  logic [7:0]  key_code_i = '0;
  logic [7:0]  disp_char_o;
  logic        disp_valid_o;
  logic        disp_done_i = 1'b0;

  int checks = 0, failures = 0;
  bit done_run = 0;

  // reference model
  bit       m_kr = 0, m_dr = 1, m_dv = 0;
  bit [7:0] m_kd = 0, m_dc = 0;

  always #2 clk_i = ~clk_i;

  kbd_disp_mmio u_kbd_disp_mmio (.*);

  function automatic logic [15:0] exp_read(bit en, bit we, logic [15:0] a);
    if (!en || we) return 16'h0;
    case (a)
      16'hFE00: return {m_kr, 15'h0};
      16'hFE02: return {8'h0, m_kd};
      16'hFE04: return {m_dr, 15'h0};
      16'hFE06: return {8'h0, m_dc};
      default:  return 16'h0;
    endcase
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic step(bit en, bit we, logic [15:0] a, logic [15:0] wd,
                      bit ks, logic [7:0] kc, bit dn, string tag);
    bit kr_n, dr_n, dv_n;
    bit [7:0] kd_n, dc_n;
    @(negedge clk_i);
    mem_en_i = en; mem_we_i = we; addr_i = a; wdata_i = wd;
    key_strobe_i = ks; key_code_i = kc; disp_done_i = dn;
    #1;
    check({tag, " rdata R2"}, rdata_o, exp_read(en, we, a));
    kr_n = m_kr; kd_n = m_kd; dr_n = m_dr; dv_n = m_dv; dc_n = m_dc;
    if (ks) begin kr_n = 1; kd_n = kc; end
    else if (en && !we && a == 16'hFE02) kr_n = 0;
    if (en && we && a == 16'hFE06 && m_dr) begin dr_n = 0; dv_n = 1; dc_n = wd[7:0]; end
    else if (m_dv && dn) begin dr_n = 1; dv_n = 0; end
    @(posedge clk_i); #1;
    m_kr = kr_n; m_kd = kd_n; m_dr = dr_n; m_dv = dv_n; m_dc = dc_n;
    check({tag, " valid R7"}, {15'h0, disp_valid_o}, {15'h0, m_dv});
    check({tag, " char R6"}, {8'h0, disp_char_o}, {8'h0, m_dc});
    mem_en_i = 0; mem_we_i = 0; key_strobe_i = 0; disp_done_i = 0;
  endtask

  task automatic rd(logic [15:0] a, string tag);
    step(1, 0, a, 16'h0, 0, 8'h0, 0, tag);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk_i);
    if (!done_run) begin
      checks++; failures++;
      $display("FAIL watchdog R1 act=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] addrs [5];
    void'($urandom(32'h5EED));
    addrs = '{16'hFE00, 16'hFE02, 16'hFE04, 16'hFE06, 16'h3000};
    repeat (3) @(posedge clk_i);
    #1;
    check("R1 valid", {15'h0, disp_valid_o}, 16'h0);
    check("R1 char", {8'h0, disp_char_o}, 16'h0);
    rst_ni = 1'b1;
    rd(16'hFE00, "R1 kstat");
    rd(16'hFE04, "R1 dstat");
    rd(16'hFE02, "R1 kdata");
    // R3: key load and overwrite
    step(0, 0, 16'h0, 16'h0, 1, 8'h41, 0, "R3 key");
    rd(16'hFE00, "R3 ready");
    step(0, 0, 16'h0, 16'h0, 1, 8'h42, 0, "R3 overwrite");
    rd(16'hFE00, "R3 still ready");
    // R4: disabled read no effect, then enabled read clears
    step(0, 0, 16'hFE02, 16'h0, 0, 8'h0, 0, "R4 no en");
    rd(16'hFE00, "R4 kept");
    step(1, 1, 16'hFE02, 16'hFFFF, 0, 8'h0, 0, "R4 write kdata");
    rd(16'hFE02, "R4 read clears");
    rd(16'hFE00, "R4 cleared");
    // R5: strobe with read
    step(1, 0, 16'hFE02, 16'h0, 1, 8'h7A, 0, "R5 collide");
    rd(16'hFE00, "R5 set wins");
    rd(16'hFE02, "R5 new code");
    // R9: status writes ignored
    step(1, 1, 16'hFE00, 16'h0000, 0, 8'h0, 0, "R9 kstat wr");
    step(1, 1, 16'hFE04, 16'h0000, 0, 8'h0, 0, "R9 dstat wr");
    rd(16'hFE04, "R9 dstat kept");
    // R6/R8/R7 display
    step(1, 1, 16'hFE06, 16'h1258, 0, 8'h0, 0, "R6 write");
    rd(16'hFE04, "R6 busy");
    step(1, 1, 16'hFE06, 16'h0059, 0, 8'h0, 0, "R8 drop");
    rd(16'hFE06, "R9 last char");
    rd(16'hFE06, "R7 hold");
    step(0, 0, 16'h0, 16'h0, 0, 8'h0, 1, "R7 done");
    step(0, 0, 16'h0, 16'h0, 0, 8'h0, 1, "R7 spurious done");
    rd(16'hFE04, "R7 ready");
    // random traffic
    for (int i = 0; i < 4000; i++) begin
      logic [15:0] a;
      a = addrs[$urandom_range(0, 4)];
      step($urandom_range(0, 3) != 0, $urandom_range(0, 1), a, 16'($urandom),
           $urandom_range(0, 7) == 0, 8'($urandom), $urandom_range(0, 3) == 0,
           "R3 R4 R5 R6 R7 R8 R9 rand");
    end
    done_run = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule